// File: doc/BRIEF.md
# Motor Driver Fault and Enable Manager

This block sits between the control pins and protection flags of a two-bridge stepper driver and the logic that drives the bridges and steps the indexer. It turns an active-low enable, an active-low sleep, an active-low indexer reset and a set of fault flags into three things: per-bridge output enables, a home-reset control for the indexer, and an input-ignore and clock-stop pair for the rest of the chip. The fault flags are one overcurrent flag per bridge, an overtemperature flag and an undervoltage flag.

Every pin and flag is asynchronous and passes through a two-flop synchroniser. Overcurrent on a bridge is latched and shuts that bridge off until the enable pin is toggled high and then low again with no overcurrent flag present, or until power-on reset. Overtemperature and undervoltage turn the bridges off only while the flag is present. Each fault onset sends the indexer home with a one-cycle pulse. The indexer reset pin and undervoltage hold it at home for as long as they last. Sleep freezes the block's response to all of its inputs and asks for the internal clocks to stop.

Top module: `bridge_fault_ctrl`

## Requirements
- R1: `drive_en_o[b]` is 1 only while awake (sleep pin high), enable pin low, reset pin high, no overtemperature, no undervoltage and bridge b not latched; in that case it is 1.
- R2: An overcurrent flag on bridge b while awake sets `ovc_latched_o[b]` and clears `drive_en_o[b]`; the other bridge keeps driving.
- R3: A latched overcurrent survives removal of the flag. Only an enable-pin rise followed by an enable-pin fall clears it, with no overcurrent flag on any bridge at either edge. A rise seen while a flag is present does not clear it.
- R4: Power-on reset (`rst_n` low) clears both latches. During it `drive_en_o`=0, `home_rst_o`=1, `ignore_in_o`=1 and `clk_stop_o`=0.
- R5: While awake, the onset of any fault gives a `home_rst_o` pulse of exactly one cycle. The faults are an overcurrent on either bridge and overtemperature.
- R6: While awake, `home_rst_o` stays high for as long as the reset pin is low or undervoltage is present.
- R7: Overtemperature and undervoltage clear all `drive_en_o` bits. Driving returns on its own when the flag drops and no latch is set.
- R8: With the enable pin high the bridges are off, while `ignore_in_o` and `home_rst_o` stay low so the indexer keeps working.
- R9: Sleep pin low sets `clk_stop_o` and `ignore_in_o` and clears `drive_en_o` and `home_rst_o`. Overcurrent flags and the reset pin have no effect while asleep.
- R10: `ignore_in_o` is 1 exactly while asleep, while the reset pin is low, or while undervoltage is present.
- R11: Outputs follow a pin change after three clock edges: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en_n_i | input | 1 | Bridge enable pin, active low |
| sleep_n_i | input | 1 | Sleep pin, active low |
| reset_n_i | input | 1 | Indexer reset pin, active low |
| ovc_i | input | NUM_BRIDGES | Overcurrent flag per bridge |
| ovt_i | input | 1 | Overtemperature flag |
| uv_i | input | 1 | Undervoltage flag |
| drive_en_o | output | NUM_BRIDGES | Bridge output enable, 0 means high impedance |
| home_rst_o | output | 1 | Indexer home reset (pulse or level) |
| ignore_in_o | output | 1 | STEP input must be ignored |
| ovc_latched_o | output | NUM_BRIDGES | Latched overcurrent per bridge |
| clk_stop_o | output | 1 | Request to stop internal clocks and charge pump |

## Verification
The assertions check on every cycle the rules that hold at each moment. A latched bridge never drives, and a synchronised overtemperature turns the bridges off on the next edge. Sleep keeps drive and home low while the clock-stop request is up. Reset or undervoltage holds home high, an overcurrent sets its latch, and a latch can fall only on a synchronised enable fall. The bench scenarios show the orderings: a clear attempt blocked by a flag at the enable rise, the exact one-cycle width of the home pulse, inputs ignored during sleep, automatic recovery from thermal and supply faults, and the three-edge latency.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    // bit positions of the single-bit controls in the synchroniser bundle
    localparam int IDX_EN_N    = 0;
    localparam int IDX_SLEEP_N = 1;
    localparam int IDX_RESET_N = 2;
    localparam int IDX_OVT     = 3;
    localparam int IDX_UV      = 4;
    localparam int CTRL_W      = 5;
    // safe values seen before the first synchronised sample
    localparam logic [CTRL_W-1:0] CTRL_RST = 5'b00011; // en_n=1, sleep_n=1, reset_n=0, no faults
endpackage

// File: rtl/bfc_sync.sv
module bfc_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else begin
                if (s == 0) stage_q[s] <= async_i;
                else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bfc_ovc_latch.sv
module bfc_ovc_latch #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          awake,
    input  logic          en_n,
    input  logic [NB-1:0] ovc,
    output logic [NB-1:0] lat_d_o,
    output logic [NB-1:0] lat_q_o
);
    typedef struct packed {
        logic [NB-1:0] lat;
        logic          armed;
        logic          en_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.en_prev = en_n;
        if (awake) begin
            if (|ovc) begin
                st_d.armed = 1'b0;
            end else if (en_n && !st_q.en_prev) begin
                st_d.armed = 1'b1;
            end else if (!en_n && st_q.en_prev && st_q.armed) begin
                st_d.lat   = '0;
                st_d.armed = 1'b0;
            end
            st_d.lat = st_d.lat | ovc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lat: '0, armed: 1'b0, en_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_d_o = st_d.lat;
    assign lat_q_o = st_q.lat;

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R2
        latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (awake && ovc[b]) |=> st_q.lat[b]);
        // R3
        latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.lat[b] && !(awake && !en_n && st_q.en_prev)) |=> st_q.lat[b]);
    end
endmodule

// File: rtl/bfc_home_gen.sv
module bfc_home_gen #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          awake,
    input  logic          hold,
    input  logic [NF-1:0] faults,
    output logic          home_o
);
    typedef struct packed {
        logic [NF-1:0] prev;
        logic          home;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.prev = awake ? faults : '0;
        st_d.home = awake && (hold || (|(faults & ~st_q.prev)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: '0, home: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign home_o = st_q.home;

    // R6
    home_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && hold) |=> home_o);
endmodule

// File: rtl/bridge_fault_ctrl.sv
module bridge_fault_ctrl
    import bfc_pkg::*;
#(
    parameter int NUM_BRIDGES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_n_i,
    input  logic                   sleep_n_i,
    input  logic                   reset_n_i,
    input  logic [NUM_BRIDGES-1:0] ovc_i,
    input  logic                   ovt_i,
    input  logic                   uv_i,
    output logic [NUM_BRIDGES-1:0] drive_en_o,
    output logic                   home_rst_o,
    output logic                   ignore_in_o,
    output logic [NUM_BRIDGES-1:0] ovc_latched_o,
    output logic                   clk_stop_o
);
    localparam int BUS_W = CTRL_W + NUM_BRIDGES;
    localparam int NF    = NUM_BRIDGES + 2;
    localparam logic [BUS_W-1:0] BUS_RST = {{NUM_BRIDGES{1'b0}}, CTRL_RST};

    logic [BUS_W-1:0]       bus_async, bus_sync;
    logic                   s_en_n, s_sleep_n, s_reset_n, s_ovt, s_uv;
    logic [NUM_BRIDGES-1:0] s_ovc, lat_d, lat_q;
    logic                   home;

    assign bus_async = {ovc_i, uv_i, ovt_i, reset_n_i, sleep_n_i, en_n_i};

    bfc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(bus_async), .sync_o(bus_sync)
    );

    assign s_en_n    = bus_sync[IDX_EN_N];
    assign s_sleep_n = bus_sync[IDX_SLEEP_N];
    assign s_reset_n = bus_sync[IDX_RESET_N];
    assign s_ovt     = bus_sync[IDX_OVT];
    assign s_uv      = bus_sync[IDX_UV];
    assign s_ovc     = bus_sync[BUS_W-1:CTRL_W];

    bfc_ovc_latch #(.NB(NUM_BRIDGES)) u_latch (
        .clk(clk), .rst_n(rst_n), .awake(s_sleep_n), .en_n(s_en_n),
        .ovc(s_ovc), .lat_d_o(lat_d), .lat_q_o(lat_q)
    );

    bfc_home_gen #(.NF(NF)) u_home (
        .clk(clk), .rst_n(rst_n), .awake(s_sleep_n),
        .hold(!s_reset_n || s_uv), .faults({s_ovc, s_ovt, s_uv}),
        .home_o(home)
    );

    typedef struct packed {
        logic [NUM_BRIDGES-1:0] drive;
        logic                   ignore;
        logic                   clkstop;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        for (int b = 0; b < NUM_BRIDGES; b++) begin
            out_d.drive[b] = s_sleep_n && !s_en_n && s_reset_n && !s_ovt && !s_uv && !lat_d[b];
        end
        out_d.ignore  = !s_sleep_n || !s_reset_n || s_uv;
        out_d.clkstop = !s_sleep_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{drive: '0, ignore: 1'b1, clkstop: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign drive_en_o    = out_q.drive;
    assign ignore_in_o   = out_q.ignore;
    assign clk_stop_o    = out_q.clkstop;
    assign ovc_latched_o = lat_q;
    assign home_rst_o    = home;

    // R1
    latched_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o & ovc_latched_o) == '0);
    // R7
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ovt |=> (drive_en_o == '0));
    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_o |-> ((drive_en_o == '0) && ignore_in_o && !home_rst_o));
endmodule

// File: tb/bridge_fault_ctrl_test.sv
module bridge_fault_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b0, sleep_n = 1'b1, reset_n = 1'b1, ovt = 1'b0, uv = 1'b0;
    logic [1:0] ovc = 2'b00;
    logic [1:0] drive, lat;
    logic       home, ign, cstop;
    int errors = 0, checks = 0, home_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bridge_fault_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_n_i(en_n), .sleep_n_i(sleep_n),
        .reset_n_i(reset_n), .ovc_i(ovc), .ovt_i(ovt), .uv_i(uv),
        .drive_en_o(drive), .home_rst_o(home), .ignore_in_o(ign),
        .ovc_latched_o(lat), .clk_stop_o(cstop)
    );

    always @(negedge clk) if (home) home_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(2);
        chk("R4 drive in reset", drive, 0);
        chk("R4 home in reset", home, 1);
        chk("R4 ignore in reset", ign, 1);
        chk("R4 clkstop in reset", cstop, 0);
        chk("R4 latch in reset", lat, 0);
        rst_n = 1'b1;
        cyc(4);
        chk("R1 drive after reset", drive, 3);
        chk("R10 ignore idle", ign, 0);
        chk("R6 home idle", home, 0);
    endtask

    task automatic t_latency;
        en_n = 1'b1;
        cyc(2);
        chk("R11 drive before third edge", drive, 3);
        cyc(1);
        chk("R11 drive after third edge", drive, 0);
        en_n = 1'b0;
        cyc(4);
    endtask

    task automatic t_ovc_latch;
        home_cnt = 0;
        ovc = 2'b01;
        cyc(3);
        ovc = 2'b00;
        cyc(6);
        chk("R2 latch bridge0", lat, 1);
        chk("R2 drive other bridge", drive, 2);
        chk("R5 one home pulse on overcurrent", home_cnt, 1);
        chk("R3 latch persists", lat, 1);
    endtask

    task automatic t_clear;
        ovc = 2'b01; en_n = 1'b1;
        cyc(4);
        ovc = 2'b00;
        cyc(4);
        en_n = 1'b0;
        cyc(4);
        chk("R3 blocked clear keeps latch", lat, 1);
        chk("R3 blocked clear drive", drive, 2);
        en_n = 1'b1;
        cyc(4);
        chk("R3 rise alone keeps latch", lat, 1);
        en_n = 1'b0;
        cyc(4);
        chk("R3 toggle clears latch", lat, 0);
        chk("R3 drive back", drive, 3);
    endtask

    task automatic t_thermal;
        home_cnt = 0;
        ovt = 1'b1;
        cyc(4);
        chk("R7 thermal drive off", drive, 0);
        chk("R7 thermal not latched", lat, 0);
        ovt = 1'b0;
        cyc(4);
        chk("R7 thermal recovers", drive, 3);
        chk("R5 one home pulse on thermal", home_cnt, 1);
    endtask

    task automatic t_uv;
        uv = 1'b1;
        cyc(4);
        chk("R6 uv holds home", home, 1);
        chk("R10 uv ignore", ign, 1);
        chk("R7 uv drive off", drive, 0);
        uv = 1'b0;
        cyc(4);
        chk("R6 uv home released", home, 0);
        chk("R7 uv recovers", drive, 3);
    endtask

    task automatic t_reset_pin;
        reset_n = 1'b0;
        cyc(5);
        chk("R6 reset pin holds home", home, 1);
        chk("R10 reset pin ignore", ign, 1);
        chk("R1 reset pin drive off", drive, 0);
        reset_n = 1'b1;
        cyc(4);
        chk("R10 reset pin released", ign, 0);
        chk("R1 drive after reset pin", drive, 3);
    endtask

    task automatic t_disable;
        home_cnt = 0;
        en_n = 1'b1;
        cyc(4);
        chk("R8 disabled drive", drive, 0);
        chk("R8 indexer not ignored", ign, 0);
        chk("R8 no home", home_cnt, 0);
        en_n = 1'b0;
        cyc(4);
    endtask

    task automatic t_sleep;
        sleep_n = 1'b0;
        cyc(4);
        home_cnt = 0;
        chk("R9 clk stop", cstop, 1);
        chk("R9 ignore", ign, 1);
        chk("R9 drive off", drive, 0);
        ovc = 2'b10; reset_n = 1'b0;
        cyc(4);
        chk("R9 no latch asleep", lat, 0);
        ovc = 2'b00; reset_n = 1'b1;
        cyc(4);
        chk("R9 no home asleep", home_cnt, 0);
        sleep_n = 1'b1;
        cyc(4);
        chk("R9 wake clk stop", cstop, 0);
        chk("R9 wake drive", drive, 3);
        chk("R9 wake latch", lat, 0);
    endtask

    task automatic t_por_clear;
        ovc = 2'b10;
        cyc(3);
        ovc = 2'b00;
        cyc(4);
        chk("R2 latch bridge1", lat, 2);
        rst_n = 1'b0;
        cyc(1);
        chk("R4 power reset clears latch", lat, 0);
        rst_n = 1'b1;
        cyc(4);
        chk("R4 drive after power reset", drive, 3);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_ovc_latch();
        t_clear();
        t_thermal();
        t_uv();
        t_reset_pin();
        t_disable();
        t_sleep();
        t_por_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule